// File: doc/BRIEF.md
# Cluster Data Router

This block is the crossbar that sits between the local memory banks of one compute cluster and the processing elements (PEs) of that cluster. It carries three traffic classes on separate channels. Input feature maps and parameters use 32-bit words, and output feature maps use 64-bit words. Each channel has its own bank-side valid/ready streams, one output port for each local PE, and one outbound port toward the neighbouring clusters. The three channels never wait on one another.

Every word carries a 2-bit delivery code and a 4-bit destination index, so the code can change from one word to the next while the block runs:

- `00` unicast: the word goes to one target. An index of 0..NUM_PE-1 picks a local PE. Any larger index sends the word out through the outbound port, with its code and index unchanged, so that a PE in another cluster can be reached.
- `01` cluster multicast: the word goes to every local PE.
- `10` array broadcast: the word goes to every local PE and to the outbound port.
- `11` reserved: the word is consumed and nothing is delivered.

A group word (multicast or broadcast) is delivered in a single cycle to all of its targets, or to none of them.

Each cycle, each channel gives words to targets in rotating bank order. The rotation starts at a pointer. Going through the banks in that order, a valid bank is granted when none of its targets has already been taken by an earlier bank in the same cycle. A granted bank completes its transfer, and sees ready, only when all of its targets are ready. The pointer is the channel's only state, and it has two transitions. On reset it goes to bank 0. In a cycle where at least one bank completes, it moves to the bank after the first completing bank in rotation order. In any other cycle it holds.

A PE's valid is raised only in the cycle in which the transfer completes. For this reason a destination's ready must not depend on its valid.

Top module: `cluster_data_router`

## Requirements
- R1: The three channels work independently. A stalled 64-bit output-feature-map transfer does not hold back a 32-bit input-feature-map transfer, and all 64 data bits reach the PE.
- R2: A unicast word (code 00) with index d < 9 raises valid and delivers the data only on PE d. The bank sees ready exactly when PE d is ready.
- R3: Unicast words from different banks to different PEs all complete in the same cycle.
- R4: A multicast word (code 01) reaches all nine local PEs and not the outbound port. Its index and the outbound ready have no effect on it.
- R5: A broadcast word (code 10) reaches all nine local PEs and the outbound port. The outbound code reads 10.
- R6: If any target of a group word is not ready, no target sees valid and the bank sees no ready. The word completes in the first cycle in which all of its targets are ready.
- R7: A unicast word with index 9..15 leaves on the outbound port, with its code and index forwarded, and no local PE sees valid.
- R8: Banks that contend for the same target are served one per cycle in rotating order. After reset, bank 0 has first priority. After a bank completes, the bank that follows it has first priority.
- R9: A reserved word (code 11) sees ready in the cycle it is offered and delivers nothing, whatever the PEs' ready inputs are.
- R10: A bank whose targets overlap those of an earlier-granted bank waits, even when its own target is ready. A later bank whose targets do not overlap still completes.
- R11: With no bank valid, no PE valid, outbound valid or bank ready is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ifm_bank_valid | input | NUM_BANKS | Input-map bank word valid |
| ifm_bank_ready | output | NUM_BANKS | Input-map bank word taken |
| ifm_bank_data | input | NUM_BANKS*IFM_W | Input-map bank data |
| ifm_bank_mode | input | NUM_BANKS*2 | Input-map delivery code |
| ifm_bank_dest | input | NUM_BANKS*DEST_W | Input-map destination index |
| ifm_pe_valid | output | NUM_PE | Input-map word to PE |
| ifm_pe_ready | input | NUM_PE | PE can take an input-map word |
| ifm_pe_data | output | NUM_PE*IFM_W | Input-map data per PE |
| ifm_ext_valid | output | 1 | Input-map outbound valid |
| ifm_ext_ready | input | 1 | Input-map outbound ready |
| ifm_ext_data | output | IFM_W | Input-map outbound data |
| ifm_ext_mode | output | 2 | Input-map outbound code |
| ifm_ext_dest | output | DEST_W | Input-map outbound index |
| prm_bank_valid | input | NUM_BANKS | Parameter bank word valid |
| prm_bank_ready | output | NUM_BANKS | Parameter bank word taken |
| prm_bank_data | input | NUM_BANKS*PRM_W | Parameter bank data |
| prm_bank_mode | input | NUM_BANKS*2 | Parameter delivery code |
| prm_bank_dest | input | NUM_BANKS*DEST_W | Parameter destination index |
| prm_pe_valid | output | NUM_PE | Parameter word to PE |
| prm_pe_ready | input | NUM_PE | PE can take a parameter word |
| prm_pe_data | output | NUM_PE*PRM_W | Parameter data per PE |
| prm_ext_valid | output | 1 | Parameter outbound valid |
| prm_ext_ready | input | 1 | Parameter outbound ready |
| prm_ext_data | output | PRM_W | Parameter outbound data |
| prm_ext_mode | output | 2 | Parameter outbound code |
| prm_ext_dest | output | DEST_W | Parameter outbound index |
| ofm_bank_valid | input | NUM_BANKS | Output-map bank word valid |
| ofm_bank_ready | output | NUM_BANKS | Output-map bank word taken |
| ofm_bank_data | input | NUM_BANKS*OFM_W | Output-map bank data |
| ofm_bank_mode | input | NUM_BANKS*2 | Output-map delivery code |
| ofm_bank_dest | input | NUM_BANKS*DEST_W | Output-map destination index |
| ofm_pe_valid | output | NUM_PE | Output-map word to PE |
| ofm_pe_ready | input | NUM_PE | PE can take an output-map word |
| ofm_pe_data | output | NUM_PE*OFM_W | Output-map data per PE |
| ofm_ext_valid | output | 1 | Output-map outbound valid |
| ofm_ext_ready | input | 1 | Output-map outbound ready |
| ofm_ext_data | output | OFM_W | Output-map outbound data |
| ofm_ext_mode | output | 2 | Output-map outbound code |
| ofm_ext_dest | output | DEST_W | Output-map outbound index |

## Verification
The hardest case to reach is a blocked group word that holds its targets while other banks compete. This case needs a known rotation pointer, one target that is not ready, and banks further down the rotation whose targets overlap the group word or stay clear of it. Each scenario of this kind starts with a fresh reset, which puts the pointer on bank 0. It then holds a single PE ready low under a broadcast or multicast word from bank 0. The bench observes the bank readies and the outbound port before and after that PE's ready rises.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
    typedef enum logic [1:0] {
        XFER_UNI   = 2'b00,
        XFER_MULTI = 2'b01,
        XFER_BCAST = 2'b10,
        XFER_RSVD  = 2'b11
    } xfer_mode_e;
endpackage

// File: rtl/cdr_target_decode.sv
// Converts one bank's delivery code and index into a target mask.
// Bit NUM_PE of the mask is the outbound port.
module cdr_target_decode #(
    parameter int NUM_PE = 9,
    parameter int DEST_W = 4,
    localparam int TGT_W = NUM_PE + 1
) (
    input  logic [1:0]        mode_i,
    input  logic [DEST_W-1:0] dest_i,
    output logic [TGT_W-1:0]  mask_o
);
    import cdr_pkg::*;

    always_comb begin
        mask_o = '0;
        unique case (xfer_mode_e'(mode_i))
            XFER_UNI: begin
                for (int p = 0; p < NUM_PE; p++) begin
                    mask_o[p] = (dest_i == DEST_W'(p));
                end
                mask_o[NUM_PE] = (dest_i >= DEST_W'(NUM_PE));
            end
            XFER_MULTI: mask_o[NUM_PE-1:0] = '1;
            XFER_BCAST: mask_o = '1;
            XFER_RSVD:  mask_o = '0;
        endcase
    end
endmodule

// File: rtl/cdr_rr_alloc.sv
// Walks the banks in rotating order starting at ptr_i.
// A bank is granted when none of its targets has already been taken.
module cdr_rr_alloc #(
    parameter int NB    = 3,
    parameter int TGT_W = 10,
    localparam int PTR_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic [NB-1:0]             req_i,
    input  logic [NB-1:0][TGT_W-1:0] mask_i,
    input  logic [PTR_W-1:0]          ptr_i,
    output logic [NB-1:0]             grant_o
);
    logic [TGT_W-1:0] claimed;
    int               idx;

    always_comb begin
        claimed = '0;
        grant_o = '0;
        idx     = 0;
        for (int k = 0; k < NB; k++) begin
            idx = (int'(ptr_i) + k) % NB;
            if (req_i[idx] && ((mask_i[idx] & claimed) == '0)) begin
                grant_o[idx] = 1'b1;
                claimed      = claimed | mask_i[idx];
            end
        end
    end
endmodule

// File: rtl/cdr_channel.sv
// One traffic channel: per-bank decode, rotating allocation,
// all-or-nothing completion and output steering.
module cdr_channel #(
    parameter int W      = 32,
    parameter int NB     = 3,
    parameter int NUM_PE = 9,
    parameter int DEST_W = 4,
    localparam int TGT_W = NUM_PE + 1,
    localparam int PTR_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NB-1:0]        bank_valid,
    output logic [NB-1:0]        bank_ready,
    input  logic [NB*W-1:0]      bank_data,
    input  logic [NB*2-1:0]      bank_mode,
    input  logic [NB*DEST_W-1:0] bank_dest,
    output logic [NUM_PE-1:0]    pe_valid,
    input  logic [NUM_PE-1:0]    pe_ready,
    output logic [NUM_PE*W-1:0]  pe_data,
    output logic                 ext_valid,
    input  logic                 ext_ready,
    output logic [W-1:0]         ext_data,
    output logic [1:0]           ext_mode,
    output logic [DEST_W-1:0]    ext_dest
);
    logic [NB-1:0][TGT_W-1:0]  mask;
    logic [NB-1:0][W-1:0]      data_arr;
    logic [NB-1:0]             grant;
    logic [NB-1:0]             fire;
    logic [TGT_W-1:0]          tgt_ready;
    logic [TGT_W-1:0]          tgt_valid;
    logic [TGT_W-1:0][W-1:0]   tgt_data;
    logic [PTR_W-1:0]          ptr_q;
    logic [PTR_W-1:0]          ptr_d;
    logic                      any_fire;
    int                        scan;

    assign tgt_ready = {ext_ready, pe_ready};

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign data_arr[b] = bank_data[b*W +: W];

        cdr_target_decode #(.NUM_PE(NUM_PE), .DEST_W(DEST_W)) u_dec (
            .mode_i (bank_mode[b*2 +: 2]),
            .dest_i (bank_dest[b*DEST_W +: DEST_W]),
            .mask_o (mask[b])
        );

        // A granted word completes only when every one of its targets is ready.
        assign fire[b] = grant[b] && ((mask[b] & ~tgt_ready) == '0);
    end

    cdr_rr_alloc #(.NB(NB), .TGT_W(TGT_W)) u_alloc (
        .req_i   (bank_valid),
        .mask_i  (mask),
        .ptr_i   (ptr_q),
        .grant_o (grant)
    );

    assign bank_ready = fire;
    assign any_fire   = |fire;

    // Rotation pointer register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (any_fire) begin
            ptr_q <= ptr_d;
        end
    end

    // Next pointer: the bank after the first completing bank in rotation order.
    always_comb begin
        ptr_d = ptr_q;
        scan  = 0;
        for (int k = NB - 1; k >= 0; k--) begin
            scan = (int'(ptr_q) + k) % NB;
            if (fire[scan]) begin
                ptr_d = PTR_W'((scan + 1) % NB);
            end
        end
    end

    // Output steering. Completing banks have disjoint targets, so an OR is enough.
    always_comb begin
        tgt_valid = '0;
        tgt_data  = '0;
        ext_mode  = '0;
        ext_dest  = '0;
        for (int b = 0; b < NB; b++) begin
            for (int t = 0; t < TGT_W; t++) begin
                if (fire[b] && mask[b][t]) begin
                    tgt_valid[t] = 1'b1;
                    tgt_data[t]  = tgt_data[t] | data_arr[b];
                end
            end
            if (fire[b] && mask[b][NUM_PE]) begin
                ext_mode = bank_mode[b*2 +: 2];
                ext_dest = bank_dest[b*DEST_W +: DEST_W];
            end
        end
    end

    for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
        assign pe_data[p*W +: W] = tgt_data[p];
    end

    assign pe_valid  = tgt_valid[NUM_PE-1:0];
    assign ext_valid = tgt_valid[NUM_PE];
    assign ext_data  = tgt_data[NUM_PE];
endmodule

// File: rtl/cluster_data_router.sv
module cluster_data_router #(
    parameter int IFM_W     = 32,
    parameter int PRM_W     = 32,
    parameter int OFM_W     = 64,
    parameter int NUM_BANKS = 3,
    parameter int NUM_PE    = 9,
    parameter int DEST_W    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_BANKS-1:0]          ifm_bank_valid,
    output logic [NUM_BANKS-1:0]          ifm_bank_ready,
    input  logic [NUM_BANKS*IFM_W-1:0]    ifm_bank_data,
    input  logic [NUM_BANKS*2-1:0]        ifm_bank_mode,
    input  logic [NUM_BANKS*DEST_W-1:0]   ifm_bank_dest,
    output logic [NUM_PE-1:0]             ifm_pe_valid,
    input  logic [NUM_PE-1:0]             ifm_pe_ready,
    output logic [NUM_PE*IFM_W-1:0]       ifm_pe_data,
    output logic                          ifm_ext_valid,
    input  logic                          ifm_ext_ready,
    output logic [IFM_W-1:0]              ifm_ext_data,
    output logic [1:0]                    ifm_ext_mode,
    output logic [DEST_W-1:0]             ifm_ext_dest,
    input  logic [NUM_BANKS-1:0]          prm_bank_valid,
    output logic [NUM_BANKS-1:0]          prm_bank_ready,
    input  logic [NUM_BANKS*PRM_W-1:0]    prm_bank_data,
    input  logic [NUM_BANKS*2-1:0]        prm_bank_mode,
    input  logic [NUM_BANKS*DEST_W-1:0]   prm_bank_dest,
    output logic [NUM_PE-1:0]             prm_pe_valid,
    input  logic [NUM_PE-1:0]             prm_pe_ready,
    output logic [NUM_PE*PRM_W-1:0]       prm_pe_data,
    output logic                          prm_ext_valid,
    input  logic                          prm_ext_ready,
    output logic [PRM_W-1:0]              prm_ext_data,
    output logic [1:0]                    prm_ext_mode,
    output logic [DEST_W-1:0]             prm_ext_dest,
    input  logic [NUM_BANKS-1:0]          ofm_bank_valid,
    output logic [NUM_BANKS-1:0]          ofm_bank_ready,
    input  logic [NUM_BANKS*OFM_W-1:0]    ofm_bank_data,
    input  logic [NUM_BANKS*2-1:0]        ofm_bank_mode,
    input  logic [NUM_BANKS*DEST_W-1:0]   ofm_bank_dest,
    output logic [NUM_PE-1:0]             ofm_pe_valid,
    input  logic [NUM_PE-1:0]             ofm_pe_ready,
    output logic [NUM_PE*OFM_W-1:0]       ofm_pe_data,
    output logic                          ofm_ext_valid,
    input  logic                          ofm_ext_ready,
    output logic [OFM_W-1:0]              ofm_ext_data,
    output logic [1:0]                    ofm_ext_mode,
    output logic [DEST_W-1:0]             ofm_ext_dest
);
    cdr_channel #(.W(IFM_W), .NB(NUM_BANKS), .NUM_PE(NUM_PE), .DEST_W(DEST_W)) u_ifm (
        .clk(clk), .rst_n(rst_n),
        .bank_valid(ifm_bank_valid), .bank_ready(ifm_bank_ready),
        .bank_data(ifm_bank_data), .bank_mode(ifm_bank_mode), .bank_dest(ifm_bank_dest),
        .pe_valid(ifm_pe_valid), .pe_ready(ifm_pe_ready), .pe_data(ifm_pe_data),
        .ext_valid(ifm_ext_valid), .ext_ready(ifm_ext_ready), .ext_data(ifm_ext_data),
        .ext_mode(ifm_ext_mode), .ext_dest(ifm_ext_dest)
    );

    cdr_channel #(.W(PRM_W), .NB(NUM_BANKS), .NUM_PE(NUM_PE), .DEST_W(DEST_W)) u_prm (
        .clk(clk), .rst_n(rst_n),
        .bank_valid(prm_bank_valid), .bank_ready(prm_bank_ready),
        .bank_data(prm_bank_data), .bank_mode(prm_bank_mode), .bank_dest(prm_bank_dest),
        .pe_valid(prm_pe_valid), .pe_ready(prm_pe_ready), .pe_data(prm_pe_data),
        .ext_valid(prm_ext_valid), .ext_ready(prm_ext_ready), .ext_data(prm_ext_data),
        .ext_mode(prm_ext_mode), .ext_dest(prm_ext_dest)
    );

    cdr_channel #(.W(OFM_W), .NB(NUM_BANKS), .NUM_PE(NUM_PE), .DEST_W(DEST_W)) u_ofm (
        .clk(clk), .rst_n(rst_n),
        .bank_valid(ofm_bank_valid), .bank_ready(ofm_bank_ready),
        .bank_data(ofm_bank_data), .bank_mode(ofm_bank_mode), .bank_dest(ofm_bank_dest),
        .pe_valid(ofm_pe_valid), .pe_ready(ofm_pe_ready), .pe_data(ofm_pe_data),
        .ext_valid(ofm_ext_valid), .ext_ready(ofm_ext_ready), .ext_data(ofm_ext_data),
        .ext_mode(ofm_ext_mode), .ext_dest(ofm_ext_dest)
    );
endmodule

// File: rtl/cdr_checker.sv
module cdr_checker #(
    parameter int IFM_W  = 32,
    parameter int OFM_W  = 64,
    parameter int NB     = 3,
    parameter int NUM_PE = 9,
    parameter int DEST_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NB-1:0]        ifm_bank_ready,
    input logic [NB*IFM_W-1:0]  ifm_bank_data,
    input logic [NB*2-1:0]      ifm_bank_mode,
    input logic [NB*DEST_W-1:0] ifm_bank_dest,
    input logic [NUM_PE-1:0]    ifm_pe_valid,
    input logic [NUM_PE-1:0]    ifm_pe_ready,
    input logic [NUM_PE*IFM_W-1:0] ifm_pe_data,
    input logic                 ifm_ext_valid,
    input logic                 ifm_ext_ready,
    input logic [1:0]           ifm_ext_mode,
    input logic [NUM_PE-1:0]    ofm_pe_valid,
    input logic [NUM_PE-1:0]    ofm_pe_ready
);
    for (genvar b = 0; b < NB; b++) begin : g_b
        for (genvar p = 0; p < NUM_PE; p++) begin : g_p
            // R2
            unicast_deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ifm_bank_ready[b] && ifm_bank_mode[b*2 +: 2] == 2'b00 &&
                 ifm_bank_dest[b*DEST_W +: DEST_W] == DEST_W'(p))
                |-> (ifm_pe_valid[p] && ifm_pe_data[p*IFM_W +: IFM_W] == ifm_bank_data[b*IFM_W +: IFM_W]));
        end
        // R4
        multicast_fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ifm_bank_ready[b] && ifm_bank_mode[b*2 +: 2] == 2'b01) |-> (&ifm_pe_valid));
        // R5
        broadcast_fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ifm_bank_ready[b] && ifm_bank_mode[b*2 +: 2] == 2'b10)
            |-> (&ifm_pe_valid && ifm_ext_valid && ifm_ext_mode == 2'b10));
    end

    // R6
    ifm_valid_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ifm_pe_valid & ~ifm_pe_ready) == '0) && !(ifm_ext_valid && !ifm_ext_ready));

    // R1
    ofm_valid_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ofm_pe_valid & ~ofm_pe_ready) == '0);

    // R11
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ifm_pe_valid || ifm_ext_valid) |-> (|ifm_bank_ready));
endmodule

bind cluster_data_router cdr_checker #(
    .IFM_W(IFM_W), .OFM_W(OFM_W), .NB(NUM_BANKS), .NUM_PE(NUM_PE), .DEST_W(DEST_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .ifm_bank_ready(ifm_bank_ready), .ifm_bank_data(ifm_bank_data),
    .ifm_bank_mode(ifm_bank_mode), .ifm_bank_dest(ifm_bank_dest),
    .ifm_pe_valid(ifm_pe_valid), .ifm_pe_ready(ifm_pe_ready), .ifm_pe_data(ifm_pe_data),
    .ifm_ext_valid(ifm_ext_valid), .ifm_ext_ready(ifm_ext_ready), .ifm_ext_mode(ifm_ext_mode),
    .ofm_pe_valid(ofm_pe_valid), .ofm_pe_ready(ofm_pe_ready)
);

// File: tb/sim_cluster_data_router.sv
module sim_cluster_data_router;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [2:0]   ifm_bank_valid, ifm_bank_ready, prm_bank_valid, prm_bank_ready, ofm_bank_valid, ofm_bank_ready;
    logic [95:0]  ifm_bank_data, prm_bank_data;
    logic [191:0] ofm_bank_data;
    logic [5:0]   ifm_bank_mode, prm_bank_mode, ofm_bank_mode;
    logic [11:0]  ifm_bank_dest, prm_bank_dest, ofm_bank_dest;
    logic [8:0]   ifm_pe_valid, ifm_pe_ready, prm_pe_valid, prm_pe_ready, ofm_pe_valid, ofm_pe_ready;
    logic [287:0] ifm_pe_data, prm_pe_data;
    logic [575:0] ofm_pe_data;
    logic         ifm_ext_valid, ifm_ext_ready, prm_ext_valid, prm_ext_ready, ofm_ext_valid, ofm_ext_ready;
    logic [31:0]  ifm_ext_data, prm_ext_data;
    logic [63:0]  ofm_ext_data;
    logic [1:0]   ifm_ext_mode, prm_ext_mode, ofm_ext_mode;
    logic [3:0]   ifm_ext_dest, prm_ext_dest, ofm_ext_dest;

    int n_chk = 0;
    int n_fail = 0;

    cluster_data_router u0 (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_all();
        ifm_bank_valid = '0; prm_bank_valid = '0; ofm_bank_valid = '0;
        ifm_bank_data = '0; prm_bank_data = '0; ofm_bank_data = '0;
        ifm_bank_mode = '0; prm_bank_mode = '0; ofm_bank_mode = '0;
        ifm_bank_dest = '0; prm_bank_dest = '0; ofm_bank_dest = '0;
        ifm_pe_ready = '1; prm_pe_ready = '1; ofm_pe_ready = '1;
        ifm_ext_ready = 1'b1; prm_ext_ready = 1'b1; ofm_ext_ready = 1'b1;
    endtask

    task automatic ifm_put(input int b, input logic [1:0] m, input logic [3:0] d, input logic [31:0] v);
        ifm_bank_valid[b] = 1'b1;
        ifm_bank_mode[b*2 +: 2] = m;
        ifm_bank_dest[b*4 +: 4] = d;
        ifm_bank_data[b*32 +: 32] = v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_all();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_idle();
        do_reset();
        #1;
        chk("R11 pe_valid idle", 64'(ifm_pe_valid), 64'h0);
        chk("R11 bank_ready idle", 64'(ifm_bank_ready), 64'h0);
        chk("R11 ext_valid idle", 64'(ifm_ext_valid), 64'h0);
    endtask

    task automatic t_unicast();
        do_reset();
        ifm_put(0, 2'b00, 4'd6, 32'hA5A5_0006);
        #1;
        chk("R2 valid one-hot", 64'(ifm_pe_valid), 64'h040);
        chk("R2 data", 64'(ifm_pe_data[6*32 +: 32]), 64'hA5A5_0006);
        chk("R2 bank ready", 64'(ifm_bank_ready), 64'h1);
        ifm_pe_ready[6] = 1'b0;
        #1;
        chk("R2 stalled valid", 64'(ifm_pe_valid), 64'h0);
        chk("R2 stalled ready", 64'(ifm_bank_ready), 64'h0);
    endtask

    task automatic t_parallel();
        do_reset();
        ifm_put(0, 2'b00, 4'd1, 32'h1111_0001);
        ifm_put(1, 2'b00, 4'd7, 32'h2222_0007);
        ifm_put(2, 2'b00, 4'd3, 32'h3333_0003);
        #1;
        chk("R3 all ready", 64'(ifm_bank_ready), 64'h7);
        chk("R3 valids", 64'(ifm_pe_valid), 64'h08A);
        chk("R3 data pe7", 64'(ifm_pe_data[7*32 +: 32]), 64'h2222_0007);
        chk("R3 data pe3", 64'(ifm_pe_data[3*32 +: 32]), 64'h3333_0003);
    endtask

    task automatic t_multicast();
        do_reset();
        ifm_ext_ready = 1'b0;
        ifm_put(1, 2'b01, 4'd12, 32'hC0DE_0101);
        #1;
        chk("R4 all pe valid", 64'(ifm_pe_valid), 64'h1FF);
        chk("R4 no ext", 64'(ifm_ext_valid), 64'h0);
        chk("R4 bank ready", 64'(ifm_bank_ready), 64'h2);
        for (int p = 0; p < 9; p++) begin
            chk("R4 data", 64'(ifm_pe_data[p*32 +: 32]), 64'hC0DE_0101);
        end
    endtask

    task automatic t_broadcast();
        do_reset();
        ifm_put(2, 2'b10, 4'd0, 32'hBCA5_7002);
        #1;
        chk("R5 all pe valid", 64'(ifm_pe_valid), 64'h1FF);
        chk("R5 ext valid", 64'(ifm_ext_valid), 64'h1);
        chk("R5 ext mode", 64'(ifm_ext_mode), 64'h2);
        chk("R5 ext data", 64'(ifm_ext_data), 64'hBCA5_7002);
        chk("R5 pe8 data", 64'(ifm_pe_data[8*32 +: 32]), 64'hBCA5_7002);
    endtask

    task automatic t_all_or_none();
        do_reset();
        ifm_pe_ready[5] = 1'b0;
        ifm_put(0, 2'b10, 4'd0, 32'h0BAD_0000);
        ifm_put(1, 2'b00, 4'd2, 32'h0000_0002);
        #1;
        chk("R6 no pe valid", 64'(ifm_pe_valid), 64'h0);
        chk("R6 no ext valid", 64'(ifm_ext_valid), 64'h0);
        chk("R6 no bank ready", 64'(ifm_bank_ready), 64'h0);
        @(negedge clk);
        ifm_pe_ready[5] = 1'b1;
        #1;
        chk("R6 released ready", 64'(ifm_bank_ready), 64'h1);
        chk("R6 released valid", 64'(ifm_pe_valid), 64'h1FF);
    endtask

    task automatic t_remote();
        do_reset();
        ifm_put(1, 2'b00, 4'd11, 32'hFA20_000B);
        #1;
        chk("R7 ext valid", 64'(ifm_ext_valid), 64'h1);
        chk("R7 ext dest", 64'(ifm_ext_dest), 64'hB);
        chk("R7 ext mode", 64'(ifm_ext_mode), 64'h0);
        chk("R7 ext data", 64'(ifm_ext_data), 64'hFA20_000B);
        chk("R7 no pe", 64'(ifm_pe_valid), 64'h0);
        ifm_ext_ready = 1'b0;
        #1;
        chk("R7 ext stall", 64'(ifm_bank_ready), 64'h0);
    endtask

    task automatic t_round_robin();
        do_reset();
        ifm_put(0, 2'b00, 4'd4, 32'h0000_AAAA);
        ifm_put(1, 2'b00, 4'd4, 32'h0000_BBBB);
        #1;
        chk("R8 first grant bank0", 64'(ifm_bank_ready), 64'h1);
        chk("R8 first data", 64'(ifm_pe_data[4*32 +: 32]), 64'h0000_AAAA);
        @(negedge clk);
        #1;
        chk("R8 second grant bank1", 64'(ifm_bank_ready), 64'h2);
        chk("R8 second data", 64'(ifm_pe_data[4*32 +: 32]), 64'h0000_BBBB);
        @(negedge clk);
        #1;
        chk("R8 wrap to bank0", 64'(ifm_bank_ready), 64'h1);
    endtask

    task automatic t_reserved();
        do_reset();
        ifm_pe_ready = '0;
        ifm_ext_ready = 1'b0;
        ifm_put(0, 2'b11, 4'd3, 32'hDEAD_0003);
        #1;
        chk("R9 consumed", 64'(ifm_bank_ready), 64'h1);
        chk("R9 no pe", 64'(ifm_pe_valid), 64'h0);
        chk("R9 no ext", 64'(ifm_ext_valid), 64'h0);
    endtask

    task automatic t_overlap();
        do_reset();
        ifm_pe_ready[3] = 1'b0;
        ifm_put(0, 2'b01, 4'd0, 32'h0000_1001);
        ifm_put(1, 2'b00, 4'd5, 32'h0000_1005);
        ifm_put(2, 2'b00, 4'd13, 32'h0000_100D);
        #1;
        chk("R10 only bank2", 64'(ifm_bank_ready), 64'h4);
        chk("R10 ext valid", 64'(ifm_ext_valid), 64'h1);
        chk("R10 no pe", 64'(ifm_pe_valid), 64'h0);
    endtask

    task automatic t_channels();
        do_reset();
        ifm_put(0, 2'b00, 4'd0, 32'h1357_9BDF);
        ofm_bank_valid[0] = 1'b1;
        ofm_bank_mode[1:0] = 2'b00;
        ofm_bank_dest[3:0] = 4'd0;
        ofm_bank_data[63:0] = 64'hDEAD_BEEF_0123_4567;
        prm_bank_valid[1] = 1'b1;
        prm_bank_mode[3:2] = 2'b10;
        prm_bank_data[63:32] = 32'h9A9A_0001;
        #1;
        chk("R1 ofm 64-bit data", ofm_pe_data[63:0], 64'hDEAD_BEEF_0123_4567);
        chk("R1 ifm data", 64'(ifm_pe_data[31:0]), 64'h1357_9BDF);
        chk("R1 prm ext", 64'(prm_ext_valid), 64'h1);
        chk("R1 ifm no ext", 64'(ifm_ext_valid), 64'h0);
        ofm_pe_ready[0] = 1'b0;
        #1;
        chk("R1 ifm unaffected", 64'(ifm_bank_ready), 64'h1);
        chk("R1 ofm stalled", 64'(ofm_bank_ready), 64'h0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle_all();
        t_reset_idle();
        t_unicast();
        t_parallel();
        t_multicast();
        t_broadcast();
        t_all_or_none();
        t_remote();
        t_round_robin();
        t_reserved();
        t_overlap();
        t_channels();
        @(negedge clk);
        idle_all();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule